// File: doc/BRIEF.md
# Selectable Bus Clock Generator

This block derives a bus-master clock enable from the base clock. A 3-bit divide code held in a byte-wide control register picks either full speed (an enable on every cycle) or a medium speed in which the enable is a one-cycle pulse once every 2, 4, 8, 16 or 32 base cycles. A free-running counter produces the pulses, so no clock is ever gated. A new divide code is adopted only at the counter wrap, so a change of speed never produces a shortened enable interval.

The same register holds a clock-output stop bit. Together with a 2-bit power-state input, this bit controls an external clock pin. The pin is modelled as a data value plus an output enable. It carries the base clock or is held high in the running and sleep states. It is always held high in software standby and is released (high impedance) in hardware standby. The register port is a plain select/write/read interface, and reads of the register are combinational.

Top module: `busclk_gen`

## Requirements
- R1: The reset input is asynchronous and active low. Its release reaches the logic on the second rising clock edge after rst_n rises. Reset clears the register to 8'h00, which gives full-speed operation with the clock pin active.
- R2: With the adopted divide code 3'b000, bm_clk_en is high on every cycle.
- R3: With an adopted divide code k in 1..5 (bits 2:0 of the register), bm_clk_en is high for one cycle out of every 2^k. The pulse falls on the cycles in which the low k bits of the free-running 5-bit counter are zero. The counter is 0 on the first cycle after the internal reset is released and then increments on every cycle.
- R4: Divide codes 3'b110 and 3'b111 are stored and read back unchanged, but once adopted they give full-speed operation.
- R5: A written divide code is adopted only on the clock edge where the counter wraps from 31 to 0. Until then the enable keeps the pattern of the previously adopted code.
- R6: Register bits 6:3 are reserved. Write data on them is discarded, and they always read as zero.
- R7: A write takes effect when reg_sel and reg_wr are both high at a rising edge. reg_rdata shows the register while reg_sel is high and is 8'h00 otherwise. Bit 7 is the stop bit.
- R8: In power state 2'b00 (run) or 2'b01 (sleep) with the stop bit at 0, clkpin_o follows the base clock and clkpin_oe is high.
- R9: In run or sleep with the stop bit at 1, clkpin_o is held high and clkpin_oe is high.
- R10: In power state 2'b10 (software standby), clkpin_o is high and clkpin_oe is high, whatever the stop bit holds.
- R11: In power state 2'b11 (hardware standby), clkpin_oe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Address decode hit for the control register |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, zero when not selected |
| pwr_state | input | 2 | 00 run, 01 sleep, 10 software standby, 11 hardware standby |
| bm_clk_en | output | 1 | Bus-master clock enable |
| clkpin_o | output | 1 | Clock pin data value |
| clkpin_oe | output | 1 | Clock pin output enable |

## Verification
The bench builds the block with its default of five divider stages, so the counter spans 32 cycles. With that setting every defined code from full speed to divide-by-32 can be reached, and the two codes above the stage count show the full-speed fallback. The short 32-cycle wrap lets the random writes land both just before and just after the adoption edge. Random power-state changes cover all four pin cases against both values of the stop bit.

// File: rtl/busclk_pkg.sv
package busclk_pkg;
  localparam int REG_W    = 8;
  localparam int CODE_W   = 3;
  localparam int STOP_BIT = 7;
  // bits kept by a write: stop bit and the divide code
  localparam logic [REG_W-1:0] WMASK = (REG_W'(1) << STOP_BIT) | REG_W'((1 << CODE_W) - 1);

  typedef enum logic [1:0] {
    PWR_RUN    = 2'b00,
    PWR_SLEEP  = 2'b01,
    PWR_SWSTBY = 2'b10,
    PWR_HWSTBY = 2'b11
  } pwr_e;
endpackage

// File: rtl/busclk_cfg_reg.sv
module busclk_cfg_reg
  import busclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic              stop,
  output logic [CODE_W-1:0] code
);
  logic [REG_W-1:0] cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (sel && wr) cfg_d = wdata & WMASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign rdata = sel ? cfg_q : '0;
  assign stop  = cfg_q[STOP_BIT];
  assign code  = cfg_q[CODE_W-1:0];
endmodule

// File: rtl/busclk_divider.sv
module busclk_divider
  import busclk_pkg::*;
#(
  parameter int DIV_STAGES = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CODE_W-1:0]     code,
  output logic                  en,
  output logic [DIV_STAGES-1:0] cnt,
  output logic [CODE_W-1:0]     act
);
  logic [DIV_STAGES-1:0] cnt_q, cnt_d;
  logic [CODE_W-1:0]     act_q, act_d;
  logic                  wrap;
  logic                  full_speed;
  logic [DIV_STAGES-1:0] mask;

  assign wrap = (cnt_q == {DIV_STAGES{1'b1}});

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    act_d = act_q;
    if (wrap) act_d = code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign full_speed = (act_q == '0) || (32'(act_q) > DIV_STAGES);
  assign mask       = ~({DIV_STAGES{1'b1}} << act_q);
  assign en         = full_speed || ((cnt_q & mask) == '0);
  assign cnt        = cnt_q;
  assign act        = act_q;
endmodule

// File: rtl/busclk_pin.sv
module busclk_pin
  import busclk_pkg::*;
(
  input  logic       clk,
  input  logic [1:0] pwr,
  input  logic       stop,
  output logic       pin_o,
  output logic       pin_oe
);
  always_comb begin
    pin_o  = 1'b1;
    pin_oe = 1'b1;
    case (pwr)
      PWR_RUN, PWR_SLEEP: pin_o = stop ? 1'b1 : clk;
      PWR_SWSTBY:         pin_o = 1'b1;
      default:            pin_oe = 1'b0;
    endcase
  end
endmodule

// File: rtl/busclk_gen.sv
module busclk_gen
  import busclk_pkg::*;
#(
  parameter int DIV_STAGES = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_sel,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic [1:0] pwr_state,
  output logic       bm_clk_en,
  output logic       clkpin_o,
  output logic       clkpin_oe
);
  logic [1:0]            rst_sync_q;
  logic                  rst_int_n;
  logic                  cfg_stop;
  logic [CODE_W-1:0]     cfg_code;
  logic [DIV_STAGES-1:0] div_cnt;
  logic [CODE_W-1:0]     div_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  busclk_cfg_reg u_reg (
    .clk   (clk),
    .rst_n (rst_int_n),
    .sel   (reg_sel),
    .wr    (reg_wr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .stop  (cfg_stop),
    .code  (cfg_code)
  );

  busclk_divider #(.DIV_STAGES(DIV_STAGES)) u_div (
    .clk   (clk),
    .rst_n (rst_int_n),
    .code  (cfg_code),
    .en    (bm_clk_en),
    .cnt   (div_cnt),
    .act   (div_act)
  );

  busclk_pin u_pin (
    .clk    (clk),
    .pwr    (pwr_state),
    .stop   (cfg_stop),
    .pin_o  (clkpin_o),
    .pin_oe (clkpin_oe)
  );
endmodule

// File: rtl/busclk_gen_chk.sv
module busclk_gen_chk
  import busclk_pkg::*;
#(
  parameter int DIV_STAGES = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [7:0]            reg_rdata,
  input logic [1:0]            pwr_state,
  input logic                  cfg_stop,
  input logic                  bm_clk_en,
  input logic                  clkpin_o,
  input logic                  clkpin_oe,
  input logic [DIV_STAGES-1:0] div_cnt,
  input logic [CODE_W-1:0]     div_act
);
  // R2
  full_speed_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_act == '0) |-> bm_clk_en);

  // R3
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((div_act != '0) && (32'(div_act) <= DIV_STAGES) && bm_clk_en) |=> !bm_clk_en);

  // R5
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_cnt != {DIV_STAGES{1'b1}}) |=> (div_act == $past(div_act)));

  // R6
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[6:3] == 4'b0000);

  // R9
  stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_stop && (pwr_state == PWR_RUN || pwr_state == PWR_SLEEP)) |-> (clkpin_o && clkpin_oe));

  // R10
  swstby_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == PWR_SWSTBY) |-> (clkpin_o && clkpin_oe));

  // R11
  hwstby_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == PWR_HWSTBY) |-> !clkpin_oe);
endmodule

bind busclk_gen busclk_gen_chk #(.DIV_STAGES(DIV_STAGES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .reg_rdata (reg_rdata),
  .pwr_state (pwr_state),
  .cfg_stop  (cfg_stop),
  .bm_clk_en (bm_clk_en),
  .clkpin_o  (clkpin_o),
  .clkpin_oe (clkpin_oe),
  .div_cnt   (div_cnt),
  .div_act   (div_act)
);

// File: tb/sim_busclk_gen.sv
`timescale 1ns/100ps
module sim_busclk_gen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_sel, reg_wr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [1:0] pwr_state;
  logic       bm_clk_en, clkpin_o, clkpin_oe;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  busclk_gen u0 (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwr_state(pwr_state),
    .bm_clk_en(bm_clk_en), .clkpin_o(clkpin_o), .clkpin_oe(clkpin_oe)
  );

  // reference model built from the requirements
  logic [1:0] m_sync;
  logic [4:0] m_cnt;
  logic [2:0] m_act, m_code;
  logic       m_stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_sync <= 2'b00;
    else        m_sync <= {m_sync[0], 1'b1};
  end

  always_ff @(posedge clk or negedge m_sync[1]) begin
    if (!m_sync[1]) begin
      m_cnt <= '0; m_act <= '0; m_code <= '0; m_stop <= 1'b0;
    end else begin
      m_cnt <= m_cnt + 1'b1;
      if (m_cnt == 5'd31) m_act <= m_code;
      if (reg_sel && reg_wr) begin
        m_stop <= reg_wdata[7];
        m_code <= reg_wdata[2:0];
      end
    end
  end

  function automatic logic exp_en(input logic [2:0] a, input logic [4:0] c);
    if (a == 3'd0 || a > 3'd5) return 1'b1;
    return (c & 5'((1 << a) - 1)) == 5'd0;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic pin_check(input logic clkval);
    if (pwr_state == 2'b11) check("R11 oe", {7'd0, clkpin_oe}, 8'd0);
    else if (pwr_state == 2'b10) check("R10 pin", {6'd0, clkpin_oe, clkpin_o}, 8'd3);
    else if (m_stop) check("R9 pin", {6'd0, clkpin_oe, clkpin_o}, 8'd3);
    else check("R8 pin", {6'd0, clkpin_oe, clkpin_o}, {6'd0, 1'b1, clkval});
  endtask

  // one cycle: drive at the falling edge, check in both clock phases
  task automatic cyc(input logic sel, input logic wr, input logic [7:0] wd, input logic [1:0] pw);
    @(negedge clk);
    reg_sel = sel; reg_wr = wr; reg_wdata = wd; pwr_state = pw;
    #1;
    pin_check(1'b0);
    @(posedge clk);
    #1;
    pin_check(1'b1);
    if (m_act == 3'd0)     check("R2 en", {7'd0, bm_clk_en}, {7'd0, exp_en(m_act, m_cnt)});
    else if (m_act <= 3'd5) check("R3 en", {7'd0, bm_clk_en}, {7'd0, exp_en(m_act, m_cnt)});
    else                   check("R4 en", {7'd0, bm_clk_en}, {7'd0, exp_en(m_act, m_cnt)});
    check("R7 rdata", reg_rdata, reg_sel ? {m_stop, 4'b0000, m_code} : 8'h00);
  endtask

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; reg_sel = 0; reg_wr = 0; reg_wdata = '0; pwr_state = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    // R1: reset state
    cyc(1, 0, 8'h00, 2'b00);
    check("R1 rdata", reg_rdata, 8'h00);
    check("R1 en", {7'd0, bm_clk_en}, 8'd1);
    // R6: reserved bits dropped
    cyc(1, 1, 8'hFF, 2'b00);
    cyc(1, 0, 8'h00, 2'b00);
    check("R6 readback", reg_rdata, 8'h87);
    // R4: code 7 stored, full speed after adoption
    repeat (40) cyc(0, 0, 8'h00, 2'b00);
    check("R4 en", {7'd0, bm_clk_en}, 8'd1);
    // R5: write /32 mid-period, still full speed next cycle
    cyc(1, 1, 8'h00, 2'b00);
    repeat (40) cyc(0, 0, 8'h00, 2'b00);
    while (m_cnt != 5'd10) cyc(0, 0, 8'h00, 2'b00);
    cyc(1, 1, 8'h05, 2'b00);
    cyc(0, 0, 8'h00, 2'b00);
    check("R5 hold", {7'd0, bm_clk_en}, 8'd1);
    repeat (60) cyc(0, 0, 8'h00, 2'b00);
    // pin states with both stop values
    for (int s = 0; s < 2; s++) begin
      cyc(1, 1, {s[0], 7'h02}, 2'b00);
      for (int p = 0; p < 4; p++) repeat (4) cyc(0, 0, 8'h00, 2'(p));
    end
    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic w;
      logic [1:0] pw;
      w  = ($urandom % 16) == 0;
      pw = (($urandom % 8) == 0) ? 2'($urandom) : pwr_state;
      cyc(1'($urandom), w, 8'($urandom), pw);
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule